// File: doc/BRIEF.md
# E1 Receive Alarm Latched-Status Unit

This block watches three receive-side alarm conditions of an E1 line and records every change in them in an 8-bit latched status register. The first condition is loss of the receive line clock. A free-running reference clock times how long the receive clock has stayed still, and the condition is raised after one channel time with no toggle. The second is the distant multiframe alarm. The block samples bit 6 of timeslot 16 in frame 0 once per multiframe, on a strobe, and the alarm changes state only after two consecutive multiframes agree on the new value. The third is a link-identification level that an external pattern recogniser decodes and delivers to the block.

Each condition has two latched flags. One sets when the condition becomes true and the other sets when it becomes false. A flag stays set until the host writes a 1 to its bit position. Every asynchronous input passes through a two-flop synchronizer into the reference clock domain before any edge is detected. A per-bit enable mask selects which latched flags drive the active-high interrupt output. The distant alarm detector runs in every signalling mode, so it has no disable input.

Top module: `e1_alarm_status`

## Requirements
- R1: After reset every status bit is 0 and `irq_o` is low.
- R2: Status layout: bit 0 distant-alarm raised, bit 1 link raised, bit 3 clock-loss raised, bit 4 distant-alarm dropped, bit 5 link dropped, bit 7 clock-loss dropped; bits 2 and 6 always read 0.
- R3: When `rx_clk_i` has not toggled for `LOSS_CYCLES` reference cycles, bit 3 sets. When toggling resumes, bit 7 sets. A receive clock that toggles more often raises neither bit.
- R4: The distant alarm asserts, setting bit 0, only when the sampled timeslot-16 bit is 1 at two consecutive multiframe strobes.
- R5: An asserted distant alarm deasserts, setting bit 4, only when the sampled bit is 0 at two consecutive strobes. A single differing sample leaves the alarm unchanged.
- R6: A rising edge on `link_id_i` sets bit 1, and a falling edge sets bit 5.
- R7: Writing with `wr_en_i` high clears each status bit whose `wr_data_i` bit is 1. Bits written with 0 keep their value, and a set bit stays set until it is cleared this way.
- R8: If a new edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: `irq_o` is 1 exactly when some status bit and the matching `irq_en_i` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock, 2.048 MHz or faster |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_clk_i | input | 1 | Receive line clock, asynchronous, watched for activity |
| mf_strobe_i | input | 1 | Multiframe strobe, one pulse per multiframe, at least two reference cycles high |
| ts16_b6_i | input | 1 | Captured bit 6 of timeslot 16, frame 0, valid around the strobe |
| link_id_i | input | 1 | Decoded link-identification level |
| wr_en_i | input | 1 | Host write enable for write-1-to-clear |
| wr_data_i | input | 8 | Host write data, a 1 clears that status bit |
| irq_en_i | input | 8 | Per-bit interrupt enable mask |
| status_o | output | 8 | Latched status register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Assertions check on every cycle that a latched bit holds unless it is cleared, and that each rise or fall of a synchronized condition sets its flag on the next edge. They also check that clock loss is declared only after the counter has run through a full quiet window, and that the distant alarm asserts only on a strobe that carries a 1. Only the bench scenarios can show the two-multiframe persistence rule across every 4-strobe pattern, the priority of a set over a clear in one cycle, the end-to-end latency through the synchronizers, and the interrupt mask over all 256 enable values.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;
  localparam int NUM_COND = 3;
  localparam int STAT_W   = 8;

  typedef enum logic [1:0] {
    COND_RDMA = 2'd0,
    COND_LINK = 2'd1,
    COND_LOSS = 2'd2
  } cond_e;

  // bits 2 and 6 unused
  localparam logic [STAT_W-1:0] STAT_USED = 8'hBB;

  function automatic int rise_pos(input int c);
    return (c == int'(COND_LOSS)) ? 3 : c;
  endfunction

  function automatic int fall_pos(input int c);
    return rise_pos(c) + 4;
  endfunction
endpackage

// File: rtl/e1_sync2.sv
module e1_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/e1_clk_loss.sv
module e1_clk_loss #(
  parameter int LOSS_CYCLES = 196
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_lvl_i,
  output logic loss_o
);
  localparam int CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          edge_seen;

  assign edge_seen = rx_lvl_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= rx_lvl_i;
      if (edge_seen)           cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign loss_o = (cnt_q == LIMIT);

  // loss is declared only after the counter has run through the full quiet window
  assert_loss_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_o) |-> ($past(cnt_q) == LIMIT - 1'b1));
endmodule

// File: rtl/e1_dist_alarm.sv
module e1_dist_alarm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic bit_i,
  output logic alarm_o
);
  logic stb_q, last_q, alarm_q;
  logic stb_rise;

  assign stb_rise = strobe_i & ~stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q   <= 1'b0;
      last_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      stb_q <= strobe_i;
      if (stb_rise) begin
        last_q <= bit_i;
        if (bit_i && last_q)        alarm_q <= 1'b1;
        else if (!bit_i && !last_q) alarm_q <= 1'b0;
      end
    end
  end

  assign alarm_o = alarm_q;

  assert_rdma_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> ($past(stb_rise) && $past(bit_i)));
  assert_rdma_drop_on_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_o) |-> ($past(stb_rise) && !$past(bit_i)));
endmodule

// File: rtl/e1_alarm_status.sv
module e1_alarm_status
  import e1_alarm_pkg::*;
#(
  parameter int LOSS_CYCLES = 196
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_clk_i,
  input  logic              mf_strobe_i,
  input  logic              ts16_b6_i,
  input  logic              link_id_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] irq_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [3:0]          sync_in, sync_out;
  logic [NUM_COND-1:0] cond, cond_q;
  logic [STAT_W-1:0]   set_vec, clr_vec, status_q;

  assign sync_in = {link_id_i, ts16_b6_i, mf_strobe_i, rx_clk_i};

  e1_sync2 #(.WIDTH(4)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_in),
    .q_o    (sync_out)
  );

  e1_clk_loss #(.LOSS_CYCLES(LOSS_CYCLES)) u_loss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_lvl_i (sync_out[0]),
    .loss_o   (cond[COND_LOSS])
  );

  e1_dist_alarm u_rdma (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (sync_out[1]),
    .bit_i    (sync_out[2]),
    .alarm_o  (cond[COND_RDMA])
  );

  assign cond[COND_LINK] = sync_out[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond;
  end

  always_comb begin
    set_vec = '0;
    for (int c = 0; c < NUM_COND; c++) begin
      set_vec[rise_pos(c)] =  cond[c] & ~cond_q[c];
      set_vec[fall_pos(c)] = ~cond[c] &  cond_q[c];
    end
  end

  assign clr_vec = wr_en_i ? wr_data_i : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (STAT_USED[i]) begin : g_used
      // set wins over a simultaneous clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         status_q[i] <= 1'b0;
        else if (set_vec[i]) status_q[i] <= 1'b1;
        else if (clr_vec[i]) status_q[i] <= 1'b0;
      end

      assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_q[i] && !clr_vec[i]) |=> status_q[i]);
    end else begin : g_unused
      assign status_q[i] = 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_COND; c++) begin : g_chk
    // covers R3, R4, R5 and R6
    assert_det_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cond[c]) |=> status_q[rise_pos(c)]);
    assert_det_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cond[c]) |=> status_q[fall_pos(c)]);
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & irq_en_i);
endmodule

// File: tb/tb_e1_alarm_status.sv
module tb_e1_alarm_status;
  localparam int LOSS = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       rx_clk_i = 1'b0, mf_strobe_i = 1'b0, ts16_b6_i = 1'b0, link_id_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0, irq_en_i = 8'hFF;
  logic [7:0] status_o;
  logic       irq_o;
  logic       rx_run = 1'b1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  e1_alarm_status #(.LOSS_CYCLES(LOSS)) dut (
    .clk_i, .rst_ni, .rx_clk_i, .mf_strobe_i, .ts16_b6_i, .link_id_i,
    .wr_en_i, .wr_data_i, .irq_en_i, .status_o, .irq_o
  );

  always #10 clk_i = ~clk_i;
  always #60 if (rx_run) rx_clk_i = ~rx_clk_i;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic host_clear(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic mf(input logic b);
    ts16_b6_i = b;
    cyc(3);
    mf_strobe_i = 1'b1;
    cyc(3);
    mf_strobe_i = 1'b0;
  endtask

  // bench model of the distant alarm
  logic m_prev = 1'b0, m_alarm = 1'b0;

  task automatic model_mf(input logic b, inout logic rose, inout logic fell);
    logic nxt;
    nxt = m_alarm;
    if (b && m_prev) nxt = 1'b1;
    else if (!b && !m_prev) nxt = 1'b0;
    if (nxt && !m_alarm) rose = 1'b1;
    if (!nxt && m_alarm) fell = 1'b1;
    m_alarm = nxt;
    m_prev = b;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R1 status after reset", status_o, 8'h00);
    check("R1 irq after reset", irq_o, 1'b0);
    rst_ni = 1'b1;

    cyc(100);
    check("R3 toggling clock gives no loss", status_o, 8'h00);

    link_id_i = 1'b1; cyc(6);
    check("R6 link rise sets bit1", status_o, 8'h02);
    check("R9 irq with bit1 enabled", irq_o, 1'b1);
    link_id_i = 1'b0; cyc(6);
    check("R6 link fall sets bit5", status_o, 8'h22);
    check("R2 unused bits zero", status_o & 8'h44, 8'h00);

    host_clear(8'h02); cyc(1);
    check("R7 clear bit1 only", status_o, 8'h20);
    host_clear(8'h00); cyc(1);
    check("R7 zero write keeps bits", status_o, 8'h20);
    cyc(20);
    check("R7 bit holds without clear", status_o, 8'h20);
    host_clear(8'hFF); cyc(1);
    check("R7 clear all", status_o, 8'h00);

    // R8: clear presented in the cycle the rise is latched (third edge after the change)
    link_id_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 8'h02;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
    check("R8 set wins over clear", status_o[1], 1'b1);
    link_id_i = 1'b0; cyc(6);
    host_clear(8'hFF); cyc(1);

    rx_run = 1'b0; cyc(LOSS + 10);
    check("R3 clock loss sets bit3", status_o, 8'h08);
    rx_run = 1'b1; cyc(20);
    check("R3 clock return sets bit7", status_o, 8'h88);
    host_clear(8'hFF); cyc(1);

    // R4/R5: sweep every 4-multiframe pattern
    for (int p = 0; p < 16; p++) begin
      logic rose, fell;
      rose = 1'b0; fell = 1'b0;
      for (int k = 3; k >= 0; k--) begin
        mf(p[k]);
        model_mf(p[k], rose, fell);
      end
      cyc(6);
      check($sformatf("R4 alarm raised, pattern %0h", p), status_o[0], rose);
      check($sformatf("R5 alarm dropped, pattern %0h", p), status_o[4], fell);
      host_clear(8'hFF); cyc(1);
    end

    // build 0xBB for the R9 sweep
    begin
      logic r, f;
      r = 1'b0; f = 1'b0;
      mf(1'b0); model_mf(1'b0, r, f);
      mf(1'b0); model_mf(1'b0, r, f);
      cyc(6);
      host_clear(8'hFF);
      mf(1'b1); mf(1'b1); mf(1'b0); mf(1'b0);
    end
    link_id_i = 1'b1; cyc(6); link_id_i = 1'b0; cyc(6);
    rx_run = 1'b0; cyc(LOSS + 10); rx_run = 1'b1; cyc(20);
    check("R2 full layout", status_o, 8'hBB);
    for (int e = 0; e < 256; e++) begin
      irq_en_i = 8'(e);
      #1;
      check($sformatf("R9 irq for mask %0h", e), irq_o, |(8'hBB & 8'(e)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule